// File: doc/BRIEF.md
# Memory-Mapped GPIO Pad Multiplexer with Soft Reset

This block holds the pad configuration for a bank of general-purpose pins: a 2-bit function select, a drive-strength code, a pull enable, an output data bit and an output enable for each pin. It also returns the level on each pad through a synchronizer. Software reaches every setting through a 32-bit register bus. Each register slot also has set, clear and toggle aliases, so software can change single bits without a read-modify-write.

Output data and output enable reach the pad only when the pin's function select is 3, which is GPIO mode. A control register holds a soft-reset bit and a clock-gate bit. Setting soft reset returns all configuration to its defaults, and the block then raises the gate bit by itself. Software polls for that bit. After software clears soft reset, the gate bit stays set and blocks configuration writes until software clears it.

Top module: `gpio_padmux`

## Requirements
- R1: After `rst_n` is low, every pad output is 0 and every register reads 0.
- R2: The word address is {slot[7:0], op[1:0]}. The slots are: control 0x00, function select 0x10+k, drive 0x20+k, pull 0x40+k, output data 0x50+k, output enable 0x60+k, input 0x70+k. With op=0 the written word replaces the register. A read at any op returns the base value, and `bus_rdata` is combinational from the address.
- R3: op=1 ORs the written mask into the register, op=2 clears the masked bits, and op=3 inverts the masked bits. Bits outside the mask keep their value.
- R4: Pin p's function select is in bits [2*(p%16)+1:2*(p%16)] of slot 0x10+p/16. It appears on `pad_fsel[2p+1:2p]`.
- R5: Pin p's drive code is in bits [4*(p%8)+1:4*(p%8)] of slot 0x20+p/8, with 0=4 mA, 1=8 mA and 2=12 mA. The upper two bits of each 4-bit field read 0. The code appears on `pad_drive[2p+1:2p]`.
- R6: Pull, output data and output enable for pin p are bit p%32 of slot base+p/32. Pull drives `pad_pull[p]`.
- R7: `pad_oe[p]` and `pad_dout[p]` equal the output-enable bit and the data bit when pin p's select is 3. Otherwise both are 0.
- R8: The input slots return `pad_in` delayed by two clock edges. Writes to the input slots have no effect.
- R9: Control bit 31 is soft reset and bit 30 is clock gate. While soft reset reads 1, each clock returns all configuration to 0. The gate bit becomes 1 on the clock after soft reset first reads 1.
- R10: While gate or soft reset is set, writes to configuration slots are ignored, and control writes are still taken. Gate cannot be cleared while soft reset is set. Gate stays set after soft reset is cleared, until software clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_waddr | input | 10 | Word address {slot, op} |
| bus_wdata | input | 32 | Write data or mask |
| bus_rdata | output | 32 | Read data for `bus_waddr` |
| pad_in | input | 96 | Pad input levels |
| pad_fsel | output | 192 | Function select, 2 bits per pin |
| pad_drive | output | 192 | Drive-strength code, 2 bits per pin |
| pad_pull | output | 96 | Pull enable per pin |
| pad_dout | output | 96 | Output value per pin, gated by GPIO mode |
| pad_oe | output | 96 | Output enable per pin, gated by GPIO mode |

## Verification
The bench checks the alias arithmetic on a single word. An implementation that treated clear as a plain write, or toggle as set, would return a different word after each step. It enables output data before GPIO mode is selected, so a design that forgets the mode gate drives the pad early.

The soft-reset test polls the control word on consecutive cycles. A design that raises the gate at the wrong time, lets the gate fall while soft reset is held, or drops the gate when soft reset clears shows a wrong control value. Configuration writes made while the gate is held must leave the registers at zero. The input test samples a changed pad across one edge and then two, which exposes a synchronizer with the wrong depth.

// File: rtl/gpio_padmux.sv
module gpio_padmux #(
  parameter int NUM_PINS = 96,
  parameter int ADDR_W   = 10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_wr,
  input  logic [ADDR_W-1:0]       bus_waddr,
  input  logic [31:0]             bus_wdata,
  output logic [31:0]             bus_rdata,
  input  logic [NUM_PINS-1:0]     pad_in,
  output logic [2*NUM_PINS-1:0]   pad_fsel,
  output logic [2*NUM_PINS-1:0]   pad_drive,
  output logic [NUM_PINS-1:0]     pad_pull,
  output logic [NUM_PINS-1:0]     pad_dout,
  output logic [NUM_PINS-1:0]     pad_oe
);
  // NUM_PINS must be a multiple of 32
  localparam int SEL_WORDS = NUM_PINS / 16;
  localparam int DRV_WORDS = NUM_PINS / 8;
  localparam int BIT_WORDS = NUM_PINS / 32;
  localparam int SLOT_W    = ADDR_W - 2;
  localparam int SLOT_CTRL = 'h00;
  localparam int SLOT_SEL  = 'h10;
  localparam int SLOT_DRV  = 'h20;
  localparam int SLOT_PULL = 'h40;
  localparam int SLOT_DOUT = 'h50;
  localparam int SLOT_DOE  = 'h60;
  localparam int SLOT_DIN  = 'h70;

  function automatic logic [31:0] merge(input logic [31:0] cur, input logic [31:0] wd,
                                        input logic [1:0] op);
    case (op)
      2'd0:    return wd;
      2'd1:    return cur | wd;
      2'd2:    return cur & ~wd;
      default: return cur ^ wd;
    endcase
  endfunction

  function automatic logic [31:0] widen(input logic [15:0] d);
    logic [31:0] w = '0;
    for (int i = 0; i < 8; i++) w[4*i +: 2] = d[2*i +: 2];
    return w;
  endfunction

  function automatic logic [15:0] narrow(input logic [31:0] w);
    logic [15:0] d;
    for (int i = 0; i < 8; i++) d[2*i +: 2] = w[4*i +: 2];
    return d;
  endfunction

  logic                  srst_q, gate_q;
  logic [2*NUM_PINS-1:0] sel_q;
  logic [2*NUM_PINS-1:0] drv_q;
  logic [NUM_PINS-1:0]   pull_q, dout_q, doe_q, sync1_q, sync2_q;

  wire [SLOT_W-1:0] slot   = bus_waddr[ADDR_W-1:2];
  wire [1:0]        op     = bus_waddr[1:0];
  wire              cfg_wr = bus_wr && !srst_q && !gate_q;  // R10
  wire              ctl_wr = bus_wr && int'(slot) == SLOT_CTRL;
  wire [31:0]       ctl_nx = merge({srst_q, gate_q, 30'b0}, bus_wdata, op);

  // R9 R10: soft reset and clock gate handshake
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srst_q <= 1'b0;
      gate_q <= 1'b0;
    end else begin
      if (ctl_wr) srst_q <= ctl_nx[31];
      if (srst_q) gate_q <= 1'b1;
      else if (ctl_wr) gate_q <= ctl_nx[30];
    end
  end

  // R8: two-flop input synchronizer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pad_in;
      sync2_q <= sync1_q;
    end
  end

  // R4: function select words
  for (genvar k = 0; k < SEL_WORDS; k++) begin : g_sel
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  sel_q[32*k +: 32] <= '0;
      else if (srst_q)                             sel_q[32*k +: 32] <= '0;
      else if (cfg_wr && int'(slot) == SLOT_SEL + k)
        sel_q[32*k +: 32] <= merge(sel_q[32*k +: 32], bus_wdata, op);
    end
  end

  // R5: drive words, two stored bits per 4-bit field
  for (genvar k = 0; k < DRV_WORDS; k++) begin : g_drv
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  drv_q[16*k +: 16] <= '0;
      else if (srst_q)                             drv_q[16*k +: 16] <= '0;
      else if (cfg_wr && int'(slot) == SLOT_DRV + k)
        drv_q[16*k +: 16] <= narrow(merge(widen(drv_q[16*k +: 16]), bus_wdata, op));
    end
  end

  // R6: single-bit banks
  for (genvar k = 0; k < BIT_WORDS; k++) begin : g_bits
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pull_q[32*k +: 32] <= '0;
        dout_q[32*k +: 32] <= '0;
        doe_q[32*k +: 32]  <= '0;
      end else if (srst_q) begin
        pull_q[32*k +: 32] <= '0;
        dout_q[32*k +: 32] <= '0;
        doe_q[32*k +: 32]  <= '0;
      end else if (cfg_wr) begin
        if (int'(slot) == SLOT_PULL + k)
          pull_q[32*k +: 32] <= merge(pull_q[32*k +: 32], bus_wdata, op);
        if (int'(slot) == SLOT_DOUT + k)
          dout_q[32*k +: 32] <= merge(dout_q[32*k +: 32], bus_wdata, op);
        if (int'(slot) == SLOT_DOE + k)
          doe_q[32*k +: 32]  <= merge(doe_q[32*k +: 32], bus_wdata, op);
      end
    end
  end

  // R2: read mux, every op returns the base value
  always_comb begin
    bus_rdata = '0;
    if (int'(slot) == SLOT_CTRL) bus_rdata = {srst_q, gate_q, 30'b0};
    for (int k = 0; k < SEL_WORDS; k++)
      if (int'(slot) == SLOT_SEL + k) bus_rdata = sel_q[32*k +: 32];
    for (int k = 0; k < DRV_WORDS; k++)
      if (int'(slot) == SLOT_DRV + k) bus_rdata = widen(drv_q[16*k +: 16]);
    for (int k = 0; k < BIT_WORDS; k++) begin
      if (int'(slot) == SLOT_PULL + k) bus_rdata = pull_q[32*k +: 32];
      if (int'(slot) == SLOT_DOUT + k) bus_rdata = dout_q[32*k +: 32];
      if (int'(slot) == SLOT_DOE + k)  bus_rdata = doe_q[32*k +: 32];
      if (int'(slot) == SLOT_DIN + k)  bus_rdata = sync2_q[32*k +: 32];
    end
  end

  // R7: pad drive only in GPIO mode (select 3)
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pad
    wire is_gpio = sel_q[2*p +: 2] == 2'd3;
    assign pad_oe[p]   = doe_q[p] & is_gpio;
    assign pad_dout[p] = dout_q[p] & is_gpio;
  end

  assign pad_fsel  = sel_q;
  assign pad_drive = drv_q;
  assign pad_pull  = pull_q;
endmodule

// File: rtl/gpio_padmux_chk.sv
module gpio_padmux_chk #(
  parameter int NUM_PINS = 96
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  srst,
  input logic                  gate,
  input logic [2*NUM_PINS-1:0] pad_fsel,
  input logic [NUM_PINS-1:0]   pad_oe,
  input logic [NUM_PINS-1:0]   pad_dout
);
  logic [NUM_PINS-1:0] gpio_mask;
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_m
    assign gpio_mask[p] = &pad_fsel[2*p +: 2];
  end

  AST_OE_ONLY_GPIO: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & ~gpio_mask) == '0);  // R7
  AST_DOUT_ONLY_GPIO: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_dout & ~gpio_mask) == '0);  // R7
  AST_GATE_AFTER_SRST: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> gate);  // R9
  AST_SRST_CLEARS_PADS: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (pad_oe == '0 && pad_fsel == '0));  // R9
  AST_GATE_LOCKS_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    (gate && !srst) |=> $stable(pad_fsel));  // R10
  AST_GATE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (gate && srst) |=> gate);  // R10
endmodule

bind gpio_padmux gpio_padmux_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .srst(srst_q), .gate(gate_q),
  .pad_fsel(pad_fsel), .pad_oe(pad_oe), .pad_dout(pad_dout)
);

// File: tb/gpio_padmux_test.sv
module gpio_padmux_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [9:0]  bus_waddr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [95:0] pad_in = '0;
  logic [191:0] pad_fsel, pad_drive;
  logic [95:0] pad_pull, pad_dout, pad_oe;
  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  gpio_padmux uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_waddr(bus_waddr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_fsel(pad_fsel), .pad_drive(pad_drive), .pad_pull(pad_pull),
    .pad_dout(pad_dout), .pad_oe(pad_oe)
  );

  function automatic logic [9:0] wa(input logic [7:0] slot, input logic [1:0] op);
    return {slot, op};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_waddr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    bus_waddr = a;
    #0.5;
    d = bus_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(wa(8'h00, 0), v); check("R1 ctrl", v, 0);
    rd(wa(8'h15, 0), v); check("R1 fsel5", v, 0);
    rd(wa(8'h61, 0), v); check("R1 doe1", v, 0);
    check("R1 pads", {31'b0, |{pad_fsel, pad_drive, pad_pull, pad_dout, pad_oe}}, 0);
  endtask

  task automatic t_rw;
    logic [31:0] v;
    wr(wa(8'h11, 0), 32'hA5A5_5A5A);
    for (int o = 0; o < 4; o++) begin
      rd(wa(8'h11, 2'(o)), v); check("R2 alias read", v, 32'hA5A5_5A5A);
    end
    check("R4 fsel word1 on pads", pad_fsel[63:32], 32'hA5A5_5A5A);
    rd(wa(8'h12, 0), v); check("R2 neighbour slot", v, 0);
    wr(wa(8'h11, 0), 32'h0);
  endtask

  task automatic t_alias;
    logic [31:0] v;
    wr(wa(8'h50, 0), 32'h0000_FF00);
    wr(wa(8'h50, 1), 32'h0F0F_0000);
    rd(wa(8'h50, 0), v); check("R3 set", v, 32'h0F0F_FF00);
    wr(wa(8'h50, 2), 32'h0000_0F00);
    rd(wa(8'h50, 0), v); check("R3 clr", v, 32'h0F0F_F000);
    wr(wa(8'h50, 3), 32'hFF00_0000);
    rd(wa(8'h50, 0), v); check("R3 tog", v, 32'hF00F_F000);
    wr(wa(8'h50, 0), 32'h0);
  endtask

  task automatic t_fsel_drive;
    logic [31:0] v;
    wr(wa(8'h12, 1), 32'h3 << 10);  // pin 37
    check("R4 pin37 select", {30'b0, pad_fsel[75:74]}, 3);
    check("R4 pin36 untouched", {30'b0, pad_fsel[73:72]}, 0);
    wr(wa(8'h21, 0), 32'hF << 20);  // pin 13
    rd(wa(8'h21, 0), v); check("R5 upper field bits read 0", v, 32'h3 << 20);
    check("R5 pin13 drive", {30'b0, pad_drive[27:26]}, 3);
    wr(wa(8'h21, 2), 32'h1 << 20);
    check("R5 pin13 12mA", {30'b0, pad_drive[27:26]}, 2);
  endtask

  task automatic t_gpio;
    wr(wa(8'h62, 1), 32'h40);  // pin 70 oe
    wr(wa(8'h52, 1), 32'h40);  // pin 70 data
    wr(wa(8'h42, 1), 32'h40);  // pin 70 pull
    check("R6 pin70 pull", {31'b0, pad_pull[70]}, 1);
    check("R7 oe masked when not GPIO", {31'b0, pad_oe[70]}, 0);
    check("R7 dout masked when not GPIO", {31'b0, pad_dout[70]}, 0);
    wr(wa(8'h14, 1), 32'h3 << 12);  // pin 70 select 3
    check("R7 oe in GPIO", {31'b0, pad_oe[70]}, 1);
    check("R7 dout in GPIO", {31'b0, pad_dout[70]}, 1);
    check("R6 only pin70 enabled", pad_oe[95:64], 32'h40);
    wr(wa(8'h14, 2), 32'h1 << 12);  // select 2
    check("R7 oe off at select 2", {31'b0, pad_oe[70]}, 0);
  endtask

  task automatic t_din;
    logic [31:0] v;
    @(negedge clk);
    pad_in[63:32] = 32'hCAFE_0123;
    @(negedge clk);
    rd(wa(8'h71, 0), v); check("R8 one edge still old", v, 0);
    @(negedge clk);
    rd(wa(8'h71, 0), v); check("R8 two edges new", v, 32'hCAFE_0123);
    wr(wa(8'h71, 0), 32'hFFFF_FFFF);
    rd(wa(8'h71, 0), v); check("R8 write ignored", v, 32'hCAFE_0123);
  endtask

  task automatic t_softrst;
    logic [31:0] v;
    wr(wa(8'h00, 1), 32'h8000_0000);
    rd(wa(8'h00, 0), v); check("R9 srst visible, gate not yet", v, 32'h8000_0000);
    @(negedge clk);
    rd(wa(8'h00, 0), v); check("R9 gate auto set", v, 32'hC000_0000);
    rd(wa(8'h42, 0), v); check("R9 pull cleared", v, 0);
    check("R9 pads cleared", {31'b0, |{pad_fsel, pad_drive, pad_pull}}, 0);
    wr(wa(8'h00, 2), 32'h4000_0000);
    rd(wa(8'h00, 0), v); check("R10 gate held during srst", v, 32'hC000_0000);
    wr(wa(8'h00, 2), 32'h8000_0000);
    rd(wa(8'h00, 0), v); check("R10 gate stays after srst off", v, 32'h4000_0000);
    wr(wa(8'h10, 0), 32'h1234_5678);
    rd(wa(8'h10, 0), v); check("R10 write blocked by gate", v, 0);
    wr(wa(8'h00, 2), 32'h4000_0000);
    rd(wa(8'h00, 0), v); check("R10 gate cleared", v, 0);
    wr(wa(8'h10, 0), 32'h1234_5678);
    rd(wa(8'h10, 0), v); check("R10 write taken after release", v, 32'h1234_5678);
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_rw;
    t_alias;
    t_fsel_drive;
    t_gpio;
    t_din;
    t_softrst;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule